// File: doc/BRIEF.md
# Sine-Table LED Brightness Sequencer

This block sets the brightness of an indicator LED. It holds a 64-entry waveform of 8-bit samples, normally one period of a sine. While the sequencer runs, it steps a pointer through the waveform and presents the addressed sample as the brightness value. While it is stopped, a static level register drives the output. A PWM stage downstream turns the value into light. On that scale 0x00 is dark, 0xFF is full brightness and 0x19 is the dimmed level.

The host fills the waveform through a byte loader. A load gives a start offset and a byte count, then streams the bytes. One load writes at most 61 bytes, so a full refill takes two loads. A configuration strobe starts or stops the sequencer. When it starts the sequencer, the strobe also supplies a 16-bit reload value, an 8-bit divisor and a repeat flag.

Timing comes from a 4 MHz tick enable. On each tick a 16-bit up-counter counts towards 0xFFFF. Each time it passes 0xFFFF it reloads, and a prescaler counts these overflows. The pointer advances once every (65536 - reload) x (divisor + 1) ticks. In repeat mode the pointer wraps to entry 0 after the last entry. In one-shot mode the output holds the last entry at the end of the first pass, and a done flag rises.

Top module: `led_wave_seq`

## Requirements
- R1: After reset the sequencer is stopped, done_o is 0, every table entry is 0x00, and bright_o shows the static level 0x19.
- R2: While stopped, bright_o equals the static level register. A write on lvl_we_i updates that register, and the new level is visible one cycle later.
- R3: A load pulse on ld_start_i captures ld_offset_i as the write address and ld_count_i as the byte budget. Each later cycle with ld_valid_i writes ld_data_i at the address, then increments the address. Address 63 wraps to 0.
- R4: A byte budget above 61 is clamped to 61. Valid bytes that arrive after the budget is used up are ignored, and a budget of 0 writes nothing.
- R5: A configuration strobe with cfg_en_i=1 starts the sequencer, or restarts it if it is already running. The strobe sets the pointer to entry 0, clears done_o, reloads both counters and latches cfg_reload_i, cfg_div_i and cfg_repeat_i. bright_o shows entry 0 from the next cycle.
- R6: While running, the pointer advances by one entry every (65536 - reload) x (div + 1) cycles in which tick_i is 1. Cycles without tick_i do not move it.
- R7: With the repeat flag at 1, the pointer steps from entry 63 back to entry 0 and the sequence continues without end.
- R8: With the repeat flag at 0, the step after entry 63 ends the pass. From then on, done_o is 1 and bright_o holds entry 63, whatever tick_i does.
- R9: A configuration strobe with cfg_en_i=0 stops the sequencer and clears done_o, and bright_o returns to the static level. The reload, divisor and repeat values presented with that strobe have no effect on later behaviour.
- R10: A table write to the entry currently shown while running appears on bright_o in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 4 MHz time-base enable, one cycle wide |
| cfg_we_i | input | 1 | Configuration strobe |
| cfg_en_i | input | 1 | 1 starts the sequencer, 0 stops it |
| cfg_reload_i | input | 16 | Reload value of the 16-bit counter |
| cfg_div_i | input | 8 | Overflow prescaler value (steps every div+1 overflows) |
| cfg_repeat_i | input | 1 | 1 = wrap after entry 63, 0 = one pass |
| lvl_we_i | input | 1 | Static level write strobe |
| lvl_i | input | 8 | Static level value |
| ld_start_i | input | 1 | Starts a table load |
| ld_offset_i | input | 6 | First table entry to write |
| ld_count_i | input | 8 | Byte budget of the load (clamped to 61) |
| ld_valid_i | input | 1 | A load data byte is present |
| ld_data_i | input | 8 | Load data byte |
| bright_o | output | 8 | Brightness value |
| done_o | output | 1 | One-shot pass has finished |

## Verification
The assertions take the strobes cfg_we_i, ld_start_i, lvl_we_i and tick_i to be synchronous single-cycle enables. They also take the pointer to be movable only by a tick while running or by a start strobe. A start strobe is expected only when the host means to restart the waveform. The bench drives every input on the falling clock edge and holds each strobe for exactly one cycle. It uses tick patterns of every cycle, every third cycle and none, and chooses reload and divisor values that keep each step period within a few thousand cycles, except for one long-period case.

// File: rtl/led_seq_pkg.sv
package led_seq_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_HOLD = 2'd2
    } seq_mode_e;

endpackage

// File: rtl/led_wave_table.sv
module led_wave_table #(
    parameter int DEPTH    = 64,
    parameter int DW       = 8,
    parameter int MAX_LOAD = 61,
    parameter int CNTW     = 8,
    localparam int AW      = $clog2(DEPTH),
    localparam int RW      = $clog2(MAX_LOAD + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld_start_i,
    input  logic [AW-1:0]   ld_offset_i,
    input  logic [CNTW-1:0] ld_count_i,
    input  logic            ld_valid_i,
    input  logic [DW-1:0]   ld_data_i,
    input  logic [AW-1:0]   rd_addr_i,
    output logic [DW-1:0]   rd_data_o
);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [AW-1:0]            addr;
        logic [RW-1:0]            rem;
    } tbl_state_t;

    tbl_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (ld_start_i) begin
            s_d.addr = ld_offset_i;
            if (ld_count_i > CNTW'(MAX_LOAD)) begin
                s_d.rem = RW'(MAX_LOAD);
            end else begin
                s_d.rem = RW'(ld_count_i);
            end
        end else if (ld_valid_i && (s_q.rem != '0)) begin
            s_d.mem[s_q.addr] = ld_data_i;
            s_d.addr          = s_q.addr + AW'(1);
            s_d.rem           = s_q.rem - RW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_data_o = s_q.mem[rd_addr_i];

endmodule

// File: rtl/led_step_timer.sv
module led_step_timer #(
    parameter int CW   = 16,
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart_i,
    input  logic [CW-1:0]   reload_i,
    input  logic [DIVW-1:0] div_i,
    input  logic            run_i,
    input  logic            tick_i,
    output logic            step_o
);

    typedef struct packed {
        logic [CW-1:0]   cnt;
        logic [DIVW-1:0] dcnt;
        logic [CW-1:0]   rl;
        logic [DIVW-1:0] dv;
    } tmr_state_t;

    tmr_state_t s_d, s_q;
    logic       wrap_w;

    assign wrap_w = (s_q.cnt == '1);
    assign step_o = run_i && tick_i && wrap_w && (s_q.dcnt == '0);

    always_comb begin
        s_d = s_q;
        if (restart_i) begin
            s_d.cnt  = reload_i;
            s_d.dcnt = div_i;
            s_d.rl   = reload_i;
            s_d.dv   = div_i;
        end else if (run_i && tick_i) begin
            if (wrap_w) begin
                s_d.cnt = s_q.rl;
                if (s_q.dcnt == '0) begin
                    s_d.dcnt = s_q.dv;
                end else begin
                    s_d.dcnt = s_q.dcnt - DIVW'(1);
                end
            end else begin
                s_d.cnt = s_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/led_wave_seq.sv
module led_wave_seq
    import led_seq_pkg::*;
#(
    parameter int          DEPTH      = 64,
    parameter int          DW         = 8,
    parameter int          CW         = 16,
    parameter int          DIVW       = 8,
    parameter int          MAX_LOAD   = 61,
    parameter int          CNTW       = 8,
    parameter logic [7:0]  STATIC_RST = 8'h19,
    localparam int         AW         = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_i,
    input  logic            cfg_we_i,
    input  logic            cfg_en_i,
    input  logic [CW-1:0]   cfg_reload_i,
    input  logic [DIVW-1:0] cfg_div_i,
    input  logic            cfg_repeat_i,
    input  logic            lvl_we_i,
    input  logic [DW-1:0]   lvl_i,
    input  logic            ld_start_i,
    input  logic [AW-1:0]   ld_offset_i,
    input  logic [CNTW-1:0] ld_count_i,
    input  logic            ld_valid_i,
    input  logic [DW-1:0]   ld_data_i,
    output logic [DW-1:0]   bright_o,
    output logic            done_o
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        seq_mode_e     mode;
        logic [AW-1:0] ptr;
        logic          rep;
        logic [DW-1:0] lvl;
    } seq_state_t;

    seq_state_t    s_d, s_q;
    logic          step_w;
    logic          start_w;
    logic          run_w;
    logic [AW-1:0] ptr_w;
    logic [DW-1:0] sample_w;

    assign start_w = cfg_we_i && cfg_en_i;
    assign run_w   = (s_q.mode == SEQ_RUN);
    assign ptr_w   = s_q.ptr;

    led_wave_table #(
        .DEPTH(DEPTH), .DW(DW), .MAX_LOAD(MAX_LOAD), .CNTW(CNTW)
    ) table_i (
        .clk(clk), .rst_n(rst_n),
        .ld_start_i(ld_start_i), .ld_offset_i(ld_offset_i),
        .ld_count_i(ld_count_i), .ld_valid_i(ld_valid_i),
        .ld_data_i(ld_data_i),
        .rd_addr_i(s_q.ptr), .rd_data_o(sample_w)
    );

    led_step_timer #(
        .CW(CW), .DIVW(DIVW)
    ) timer_i (
        .clk(clk), .rst_n(rst_n),
        .restart_i(start_w), .reload_i(cfg_reload_i), .div_i(cfg_div_i),
        .run_i(run_w), .tick_i(tick_i), .step_o(step_w)
    );

    always_comb begin
        s_d = s_q;
        if (lvl_we_i) begin
            s_d.lvl = lvl_i;
        end
        if (cfg_we_i) begin
            if (cfg_en_i) begin
                s_d.mode = SEQ_RUN;
                s_d.ptr  = '0;
                s_d.rep  = cfg_repeat_i;
            end else begin
                s_d.mode = SEQ_IDLE;
            end
        end else if (run_w && step_w) begin
            if (s_q.ptr == LAST) begin
                if (s_q.rep) begin
                    s_d.ptr = '0;
                end else begin
                    s_d.mode = SEQ_HOLD;
                end
            end else begin
                s_d.ptr = s_q.ptr + AW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.mode <= SEQ_IDLE;
            s_q.lvl  <= STATIC_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign bright_o = (s_q.mode == SEQ_IDLE) ? s_q.lvl : sample_w;
    assign done_o   = (s_q.mode == SEQ_HOLD);

endmodule

// File: rtl/led_wave_seq_chk.sv
module led_wave_seq_chk #(
    parameter int AW    = 6,
    parameter int DEPTH = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick_i,
    input logic          cfg_we_i,
    input logic          cfg_en_i,
    input logic          done_o,
    input logic [AW-1:0] ptr,
    input logic          running
);

    AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we_i && cfg_en_i) |=> (ptr == '0 && running && !done_o)); // R5

    AST_NO_TICK_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !cfg_we_i) |=> $stable(ptr)); // R6

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !cfg_we_i) |=> (ptr == $past(ptr) || ptr == AW'($past(ptr) + AW'(1)))); // R7

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !cfg_we_i) |=> done_o); // R8

    AST_DONE_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (ptr == AW'(DEPTH - 1) && !running)); // R8

    AST_CFG_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we_i |=> !done_o); // R9

    AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we_i && !cfg_en_i) |=> !running); // R9

endmodule

bind led_wave_seq led_wave_seq_chk #(.AW(AW), .DEPTH(DEPTH)) chk_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cfg_we_i(cfg_we_i),
    .cfg_en_i(cfg_en_i), .done_o(done_o), .ptr(ptr_w), .running(run_w)
);

// File: tb/led_wave_seq_tb.sv
module led_wave_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 120000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       cfg_we_i = 1'b0;
    logic       cfg_en_i = 1'b0;
    logic [15:0] cfg_reload_i = '0;
    logic [7:0] cfg_div_i = '0;
    logic       cfg_repeat_i = 1'b0;
    logic       lvl_we_i = 1'b0;
    logic [7:0] lvl_i = '0;
    logic       ld_start_i = 1'b0;
    logic [5:0] ld_offset_i = '0;
    logic [7:0] ld_count_i = '0;
    logic       ld_valid_i = 1'b0;
    logic [7:0] ld_data_i = '0;
    logic [7:0] bright_o;
    logic       done_o;

    led_wave_seq dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .cfg_we_i(cfg_we_i), .cfg_en_i(cfg_en_i), .cfg_reload_i(cfg_reload_i),
        .cfg_div_i(cfg_div_i), .cfg_repeat_i(cfg_repeat_i),
        .lvl_we_i(lvl_we_i), .lvl_i(lvl_i),
        .ld_start_i(ld_start_i), .ld_offset_i(ld_offset_i),
        .ld_count_i(ld_count_i), .ld_valid_i(ld_valid_i), .ld_data_i(ld_data_i),
        .bright_o(bright_o), .done_o(done_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    finished = 1'b0;
    string phase = "R1";

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_mem[64];
    int m_lvl, m_mode, m_ptr, m_cnt, m_dcnt, m_rl, m_dv, m_rep, m_addr, m_rem;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            foreach (m_mem[i]) m_mem[i] = 0;
            m_lvl = 'h19; m_mode = 0; m_ptr = 0; m_cnt = 0; m_dcnt = 0;
            m_rl = 0; m_dv = 0; m_rep = 0; m_addr = 0; m_rem = 0;
        end else begin
            if (ld_start_i) begin
                m_addr = int'(ld_offset_i);
                m_rem  = (ld_count_i > 61) ? 61 : int'(ld_count_i);
            end else if (ld_valid_i && m_rem > 0) begin
                m_mem[m_addr] = int'(ld_data_i);
                m_addr = (m_addr + 1) % 64;
                m_rem--;
            end
            if (lvl_we_i) m_lvl = int'(lvl_i);
            if (cfg_we_i) begin
                if (cfg_en_i) begin
                    m_mode = 1; m_ptr = 0;
                    m_rl = int'(cfg_reload_i); m_dv = int'(cfg_div_i);
                    m_cnt = m_rl; m_dcnt = m_dv; m_rep = int'(cfg_repeat_i);
                end else begin
                    m_mode = 0;
                end
            end else if (m_mode == 1 && tick_i) begin
                if (m_cnt == 65535) begin
                    m_cnt = m_rl;
                    if (m_dcnt == 0) begin
                        m_dcnt = m_dv;
                        if (m_ptr == 63) begin
                            if (m_rep != 0) m_ptr = 0;
                            else m_mode = 2;
                        end else begin
                            m_ptr++;
                        end
                    end else begin
                        m_dcnt--;
                    end
                end else begin
                    m_cnt++;
                end
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(phase, int'(bright_o), (m_mode == 0) ? m_lvl : m_mem[m_ptr]);
            chk(phase, int'(done_o), (m_mode == 2) ? 1 : 0);
        end
    end

    // ---------------- tick generator ----------------
    int tick_per = 0;
    int tick_ph = 0;
    always @(negedge clk) begin
        if (tick_per == 0) begin
            tick_i <= 1'b0;
        end else begin
            tick_ph = (tick_ph + 1) % tick_per;
            tick_i <= (tick_ph == 0);
        end
    end

    // ---------------- watchdog ----------------
    int cyc_cnt = 0;
    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > WATCHDOG && !finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cyc_cnt, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    int expt[64];

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load_start(input int off, input int cnt);
        @(negedge clk);
        ld_start_i = 1'b1; ld_offset_i = 6'(off); ld_count_i = 8'(cnt);
        @(negedge clk);
        ld_start_i = 1'b0;
    endtask

    task automatic load_byte(input int d);
        ld_valid_i = 1'b1; ld_data_i = 8'(d);
        @(negedge clk);
        ld_valid_i = 1'b0;
    endtask

    task automatic cfg(input bit en, input int rl, input int dv, input bit rep);
        @(negedge clk);
        cfg_we_i = 1'b1; cfg_en_i = en; cfg_reload_i = 16'(rl);
        cfg_div_i = 8'(dv); cfg_repeat_i = rep;
        @(negedge clk);
        cfg_we_i = 1'b0; cfg_en_i = 1'b0;
    endtask

    initial begin
        foreach (expt[i]) expt[i] = 0;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        phase = "R1";
        chk("R1 reset level", int'(bright_o), 'h19);
        chk("R1 reset done", int'(done_o), 0);

        phase = "R2";
        @(negedge clk); lvl_we_i = 1'b1; lvl_i = 8'h80;
        @(negedge clk); lvl_we_i = 1'b0;
        chk("R2 static level", int'(bright_o), 'h80);

        phase = "R3";
        load_start(0, 61);
        for (int i = 0; i < 61; i++) load_byte((i * 7 + 3) & 255);
        load_start(61, 5);
        for (int k = 0; k < 5; k++) load_byte('hA0 + k);
        expt[61] = 'hA0; expt[62] = 'hA1; expt[63] = 'hA2;
        expt[0] = 'hA3; expt[1] = 'hA4;

        phase = "R4";
        load_byte('h11);
        load_byte('h12);
        load_start(10, 0);
        for (int k = 0; k < 3; k++) load_byte('hEE);
        load_start(2, 200);
        for (int j = 0; j < 63; j++) load_byte('h40 + j);
        for (int i = 2; i < 63; i++) expt[i] = 'h40 + (i - 2);
        chk("R4 table untouched while stopped", int'(bright_o), 'h80);

        phase = "R5";
        tick_per = 1;
        cyc(2);
        cfg(1'b1, 'hFFFE, 1, 1'b1);
        chk("R5 start shows entry 0", int'(bright_o), expt[0]);
        chk("R5 start clears done", int'(done_o), 0);
        phase = "R6";
        cyc(3);
        chk("R6 entry 0 held for 4 ticks", int'(bright_o), expt[0]);
        cyc(1);
        chk("R6 entry 1 after 4 ticks", int'(bright_o), expt[1]);
        cyc(3);
        chk("R6 entry 1 clamped-load value", int'(bright_o), expt[1]);
        cyc(1);
        chk("R4 entry 2 from clamped load", int'(bright_o), expt[2]);

        phase = "R7";
        cyc(300);
        phase = "R6";
        tick_per = 3;
        cfg(1'b1, 'hFFFD, 2, 1'b1);
        cyc(200);
        tick_per = 0;
        cyc(100);
        tick_per = 1;

        phase = "R10";
        cfg(1'b1, 'hFF00, 3, 1'b1);
        load_start(0, 1);
        load_byte('h5A);
        expt[0] = 'h5A;
        chk("R10 live write visible", int'(bright_o), 'h5A);

        phase = "R5";
        cfg(1'b1, 'hFFFF, 0, 1'b0);
        cyc(20);
        cfg(1'b1, 'hFFFF, 0, 1'b0);
        chk("R5 restart shows entry 0", int'(bright_o), expt[0]);

        phase = "R8";
        cyc(80);
        chk("R8 one-shot done", int'(done_o), 1);
        chk("R8 one-shot holds last entry", int'(bright_o), expt[63]);
        cyc(20);
        chk("R8 still held", int'(bright_o), expt[63]);

        phase = "R9";
        cfg(1'b0, 'h1234, 'h77, 1'b1);
        chk("R9 stop shows static", int'(bright_o), 'h80);
        chk("R9 stop clears done", int'(done_o), 0);
        cyc(50);
        chk("R9 still static", int'(bright_o), 'h80);

        phase = "R6";
        cfg(1'b1, 'hF000, 2, 1'b1);
        cyc(12286);
        chk("R6 long period before step", int'(bright_o), expt[0]);
        cyc(2);
        chk("R6 long period after step", int'(bright_o), expt[1]);
        cyc(12400);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule